// File: doc/BRIEF.md
# I2C Bus Clock Phase Generator

This block produces the bus clock of an I2C controller together with two single-cycle strobes. One strobe tells the data path when it may change SDA. The other tells it when to sample SDA. Timing comes from one 32-bit configuration word with five fields. A prescaler cuts the kernel clock into time quanta. A low count and a high count set how many quanta each clock phase lasts. A hold delay places the SDA change after the falling edge. A setup delay guarantees a minimum gap between that change and the next rising edge.

The pad is modelled as a drive-low enable and a sampled line input. After the block releases the clock, it waits until the synchronised line reads high before it counts the high phase. Slow rise times and targets that hold the clock low therefore stretch the period. If another device pulls the line low during the high phase, the high phase ends early. The configuration word can only be loaded while the generator is disabled. Disabling the generator releases the clock at once, and the next enable starts again from a fresh low phase.

Top module: `i2c_scl_timegen`

## Requirements
- R1: After reset, and while `enable` is low, `scl_drive_low`, `sda_change_stb` and `sda_sample_stb` stay low.
- R2: `cfg_word` is captured on a cycle where `cfg_we` is high and `enable` is low. A write in a cycle where `enable` is high is ignored, including the cycle in which `enable` first rises. Field layout: prescaler P = [31:28], setup S = [23:20], hold D = [19:16], high count H = [15:8], low count L = [7:0]. Bits [27:24] are unused.
- R3: Each low phase drives the clock low for (E+1)*(P+1) kernel cycles, where E = max(L, D+S+1).
- R4: The release phase lasts SYNC_STAGES+1+(H+1)*(P+1) cycles when the line follows the pad. Each cycle that the line is held low by someone else after release adds one cycle.
- R5: `sda_change_stb` pulses exactly once per low phase, in cycle D*(P+1)+P, counted from 0 at the first cycle of that phase.
- R6: When D+S+1 exceeds L, the low phase is lengthened so that the gap from the change strobe to the release is at least S+1 quanta.
- R7: `sda_sample_stb` pulses exactly once per release phase, in the first cycle where the synchronised line reads high. That is cycle SYNC_STAGES of the release phase if the line rises at once.
- R8: If the synchronised line goes low during the high phase, a new low phase starts at once. The pad drives low SYNC_STAGES+1 cycles after the external pull begins, and that low phase has full length.
- R9: The cycle after `enable` is seen low, the clock is released and no strobe fires. A later enable starts a full-length low phase on the next cycle.
- R10: The two strobes are never high in the same cycle, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Generator enable; the configuration is locked while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | 32 | Packed timing configuration |
| scl_in | input | 1 | Clock line level seen at the pad |
| scl_drive_low | output | 1 | Pull the clock line low when high |
| sda_change_stb | output | 1 | One-cycle permission to change SDA |
| sda_sample_stb | output | 1 | One-cycle SDA sample point at the rising edge |

## Verification
Two events can fall on the same cycle. A configuration write can coincide with the rising edge of `enable`, and an external pull-low can coincide with high-phase counting.

- **Write on the enable edge.** The bench raises `enable` and pulses `cfg_we` with a different word on the same clock. It judges the outcome by measuring the next period: the period must match the previously loaded word.
- **Pull-low during the high phase.** The bench pulls the line low a few cycles into the high phase. It expects the pad to drive low exactly SYNC_STAGES+1 cycles later, followed by a full-length low phase.

// File: rtl/i2c_tgen_pkg.sv
package i2c_tgen_pkg;
  localparam int PRESC_W   = 4;
  localparam int DLY_W     = 4;
  localparam int CNT_W     = 8;
  localparam int LOW_LSB   = 0;
  localparam int HIGH_LSB  = 8;
  localparam int HOLD_LSB  = 16;
  localparam int SETUP_LSB = 20;
  localparam int PRESC_LSB = 28;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic [DLY_W-1:0]   setup;
    logic [DLY_W-1:0]   hold;
    logic [CNT_W-1:0]   high;
    logic [CNT_W-1:0]   low;
  } tgen_cfg_t;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_RISE, PH_HIGH} phase_e;

  function automatic tgen_cfg_t unpack_word(input logic [31:0] w);
    tgen_cfg_t c;
    c.presc = w[PRESC_LSB +: PRESC_W];
    c.setup = w[SETUP_LSB +: DLY_W];
    c.hold  = w[HOLD_LSB  +: DLY_W];
    c.high  = w[HIGH_LSB  +: CNT_W];
    c.low   = w[LOW_LSB   +: CNT_W];
    return c;
  endfunction
endpackage

// File: rtl/i2c_tgen_cfg.sv
module i2c_tgen_cfg
  import i2c_tgen_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        cfg_we,
  input  logic [31:0] cfg_word,
  output tgen_cfg_t   cfg
);
  tgen_cfg_t cfg_q;
  logic      rsv_unused;

  assign rsv_unused = ^cfg_word[27:24];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_we && !enable) cfg_q <= unpack_word(cfg_word);
  end

  assign cfg = cfg_q;

  // R2
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable(cfg_q));
endmodule

// File: rtl/i2c_tgen_sync.sv
module i2c_tgen_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= {STAGES{RST_VAL}};
        else        sh <= {sh[STAGES-2:0], d};
      end
      assign q = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2c_tgen_quantum.sv
module i2c_tgen_quantum #(
  parameter int PW = i2c_tgen_pkg::PRESC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [PW-1:0] presc,
  output logic          tick
);
  logic [PW-1:0] pc_q;

  assign tick = !clear && (pc_q == presc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         pc_q <= '0;
    else if (clear || (pc_q == presc))  pc_q <= '0;
    else                                pc_q <= pc_q + PW'(1);
  end

  // R3
  pc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> (pc_q <= presc));
endmodule

// File: rtl/i2c_tgen_phase.sv
module i2c_tgen_phase
  import i2c_tgen_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  tgen_cfg_t cfg,
  input  logic      scl_sync,
  input  logic      tick,
  output logic      qclear,
  output logic      drive_low,
  output logic      chg_stb,
  output logic      smp_stb
);
  phase_e        state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] guard_idx, end_idx;
  logic          low_done, high_done, pulled;

  always_comb begin
    guard_idx = CW'(cfg.hold) + CW'(cfg.setup) + CW'(1);
    end_idx   = (CW'(cfg.low) >= guard_idx) ? CW'(cfg.low) : guard_idx;
  end

  assign low_done  = tick && (cnt_q == end_idx);
  assign high_done = tick && (cnt_q == CW'(cfg.high));
  assign pulled    = (state_q == PH_HIGH) && !scl_sync;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE: state_d = PH_LOW;
      PH_LOW:  if (low_done) state_d = PH_RISE;
      PH_RISE: if (scl_sync) state_d = PH_HIGH;
      PH_HIGH: if (pulled || high_done) state_d = PH_LOW;
      default: state_d = PH_IDLE;
    endcase
    if (!enable) state_d = PH_IDLE;
  end

  always_comb begin
    if (state_d != state_q)                                  cnt_d = '0;
    else if (tick && (state_q inside {PH_LOW, PH_HIGH}))     cnt_d = cnt_q + CW'(1);
    else                                                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign qclear    = (state_q == PH_IDLE) || (state_q == PH_RISE) || pulled;
  assign drive_low = (state_q == PH_LOW);
  assign chg_stb   = enable && (state_q == PH_LOW) && tick && (cnt_q == CW'(cfg.hold));
  assign smp_stb   = enable && (state_q == PH_RISE) && scl_sync;

  // R8
  pull_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulled && enable) |=> (state_q == PH_LOW) && (cnt_q == '0));
  // R4
  high_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PH_HIGH) && tick) |-> scl_sync);
  // R5
  chg_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_stb |-> drive_low);
  // R7
  smp_enters_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> (state_q == PH_HIGH) || !enable);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(chg_stb && smp_stb));
  // R10
  chg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_stb |=> !chg_stb);
endmodule

// File: rtl/i2c_scl_timegen.sv
module i2c_scl_timegen
  import i2c_tgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        cfg_we,
  input  logic [31:0] cfg_word,
  input  logic        scl_in,
  output logic        scl_drive_low,
  output logic        sda_change_stb,
  output logic        sda_sample_stb
);
  tgen_cfg_t cfg;
  logic      scl_sync, tick, qclear;

  i2c_tgen_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_we(cfg_we), .cfg_word(cfg_word), .cfg(cfg)
  );

  i2c_tgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_sync)
  );

  i2c_tgen_quantum #(.PW(PRESC_W)) u_quantum (
    .clk(clk), .rst_n(rst_n), .clear(qclear), .presc(cfg.presc), .tick(tick)
  );

  i2c_tgen_phase #(.CW(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg(cfg),
    .scl_sync(scl_sync), .tick(tick), .qclear(qclear),
    .drive_low(scl_drive_low), .chg_stb(sda_change_stb), .smp_stb(sda_sample_stb)
  );

  // R9
  disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_drive_low);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !sda_change_stb && !sda_sample_stb);
  // R7
  smp_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_sample_stb |-> !scl_drive_low);
endmodule

// File: tb/i2c_scl_timegen_test.sv
module i2c_scl_timegen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        ext_hold = 1'b0;
  logic        scl_in;
  logic        scl_drive_low, sda_change_stb, sda_sample_stb;
  int          errors = 0;
  int          checks = 0;
  bit          done = 0;

  localparam int SYNC = 2;

  always #4 clk = ~clk;

  assign scl_in = ~(scl_drive_low | ext_hold);

  i2c_scl_timegen #(.SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_word(cfg_word), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .sda_change_stb(sda_change_stb), .sda_sample_stb(sda_sample_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int p, int su, int ho, int hi, int lo);
    return {p[3:0], 4'h0, su[3:0], ho[3:0], hi[7:0], lo[7:0]};
  endfunction

  function automatic int e_low(logic [31:0] w);
    int p, e, g;
    p = w[31:28]; g = w[19:16] + w[23:20] + 1;
    e = (w[7:0] >= g) ? w[7:0] : g;
    return (e + 1) * (p + 1);
  endfunction
  function automatic int e_rel(logic [31:0] w);
    return SYNC + 1 + (w[15:8] + 1) * (w[31:28] + 1);
  endfunction
  function automatic int e_chg(logic [31:0] w);
    return w[19:16] * (w[31:28] + 1) + w[31:28];
  endfunction

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk); cfg_word = w; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic load_and_run(input logic [31:0] w);
    @(negedge clk); enable = 1'b0;
    write_cfg(w);
    enable = 1'b1;
  endtask

  task automatic measure(input int stretch_n, input int pull_at,
                         output int lo, output int rel, output int chg_i,
                         output int chg_n, output int smp_i, output int smp_n);
    int cnt;
    @(negedge clk);
    while (scl_drive_low) @(negedge clk);
    while (!scl_drive_low) @(negedge clk);
    cnt = 0; chg_i = -1; chg_n = 0; smp_i = -1; smp_n = 0;
    if (stretch_n >= 0) ext_hold = 1'b1;
    while (scl_drive_low) begin
      if (sda_change_stb) begin chg_i = cnt; chg_n++; end
      if (sda_sample_stb) smp_n++;
      cnt++;
      @(negedge clk);
    end
    lo = cnt;
    cnt = 0;
    while (!scl_drive_low) begin
      if (sda_sample_stb) begin smp_i = cnt; smp_n++; end
      if (sda_change_stb) chg_n++;
      if (cnt == stretch_n) ext_hold = 1'b0;
      if (cnt == pull_at) ext_hold = 1'b1;
      cnt++;
      @(negedge clk);
    end
    rel = cnt;
    ext_hold = 1'b0;
  endtask

  task automatic t_reset();
    int bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (scl_drive_low || sda_change_stb || sda_sample_stb) bad++;
    end
    check(bad == 0, "R1 outputs quiet after reset", bad, 0);
  endtask

  task automatic t_period(input logic [31:0] w, input string req_low);
    int lo, rel, ci, cn, si, sn;
    load_and_run(w);
    measure(-1, -1, lo, rel, ci, cn, si, sn);
    check(lo == e_low(w), req_low, lo, e_low(w));
    check(rel == e_rel(w), "R4 release length", rel, e_rel(w));
    check(ci == e_chg(w), "R5 change strobe position", ci, e_chg(w));
    check(cn == 1, "R10 one change strobe per low phase", cn, 1);
    check(si == SYNC, "R7 sample strobe position", si, SYNC);
    check(sn == 1, "R10 one sample strobe per release", sn, 1);
  endtask

  task automatic t_cfg_lock();
    logic [31:0] wa, wb;
    int lo, rel, ci, cn, si, sn;
    wa = mk(0, 2, 0, 2, 4);
    wb = mk(1, 3, 2, 4, 9);
    load_and_run(wa);
    write_cfg(wb);
    measure(-1, -1, lo, rel, ci, cn, si, sn);
    check(lo == e_low(wa), "R2 write while enabled ignored", lo, e_low(wa));
    load_and_run(wb);
    measure(-1, -1, lo, rel, ci, cn, si, sn);
    check(lo == e_low(wb), "R2 write while disabled taken", lo, e_low(wb));
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1; cfg_word = wa; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
    measure(-1, -1, lo, rel, ci, cn, si, sn);
    check(lo == e_low(wb), "R2 write on enable edge ignored", lo, e_low(wb));
    check(rel == e_rel(wb), "R2 release unchanged", rel, e_rel(wb));
  endtask

  task automatic t_stretch();
    logic [31:0] w;
    int lo, rel, ci, cn, si, sn;
    w = mk(1, 3, 2, 4, 9);
    load_and_run(w);
    measure(7, -1, lo, rel, ci, cn, si, sn);
    check(rel == e_rel(w) + 7, "R4 stretched release length", rel, e_rel(w) + 7);
    check(si == SYNC + 7, "R7 sample waits for line", si, SYNC + 7);
  endtask

  task automatic t_early();
    logic [31:0] w;
    int lo, rel, ci, cn, si, sn, lo2;
    w = mk(3, 4, 2, 15, 19);
    load_and_run(w);
    measure(-1, SYNC + 3, lo, rel, ci, cn, si, sn);
    check(rel == SYNC + 3 + SYNC + 1, "R8 pull-low ends high phase", rel, SYNC + 3 + SYNC + 1);
    lo2 = 0;
    while (scl_drive_low) begin lo2++; @(negedge clk); end
    check(lo2 == e_low(w), "R8 full low after pull", lo2, e_low(w));
  endtask

  task automatic t_disable();
    logic [31:0] w;
    int bad, lo;
    w = mk(3, 4, 2, 15, 19);
    load_and_run(w);
    @(negedge clk);
    while (scl_drive_low) @(negedge clk);
    while (!scl_drive_low) @(negedge clk);
    repeat (10) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(!scl_drive_low, "R9 released after disable", scl_drive_low, 0);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (scl_drive_low || sda_change_stb || sda_sample_stb) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R9 quiet while disabled", bad, 0);
    enable = 1'b1;
    @(negedge clk);
    lo = 0;
    while (scl_drive_low) begin lo++; @(negedge clk); end
    check(lo == e_low(w), "R9 fresh low phase on re-enable", lo, e_low(w));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_period(mk(0, 2, 0, 2, 4),   "R3 low length fast");
    t_period(mk(1, 3, 2, 4, 9),   "R3 low length medium");
    t_period(mk(3, 4, 2, 15, 19), "R3 low length slow");
    t_period(mk(0, 4, 3, 1, 2),   "R6 low stretched by hold plus setup");
    t_cfg_lock();
    t_stretch();
    t_early();
    t_disable();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule